// File: doc/BRIEF.md
# Latched Fault and Status Register Pair for a Dual H-Bridge Driver

This block holds the fault and status flags of a motor driver with two H-bridges. The driver has eight power transistors, a supply monitor, a temperature sensor, stall detection, open-load detection on each bridge and a reference-current check. One-cycle pulses and level indications from these monitors are caught in two 13-bit registers. A flag stays set until software clears it or reset is applied. A serial front end that is not part of this block writes the registers through a strobe with an address and data, and reads them through a combinational read port.

The fault register holds the overcurrent, supply and temperature flags. The status/control register holds stall, reference error and per-bridge open-load flags, plus three control bits: PWM frequency select, glitch-filter time select, and mirroring of the stall flag onto the PWM pin. Each register has its own clear bit, which always reads back as 0. A latched thermal shutdown holds the bridges off until the fault register's clear bit is written.

Register selection uses the same encoding for reads and writes: address 0 is the status/control register and address 1 is the fault register. Reset is asynchronous and active low. Its release is synchronised inside the block, so flags can start to set two clock edges after `rst_n` rises.

Top module: `fault_status_bank`

## Requirements
- R1: While reset is active, both registers read 0 and `bridge_off`, `pwm_freq_sel`, `filt_time_sel`, `pwm_mirror_en` and `pwm_mirror_lvl` are 0.
- R2: A 1 on `ocp_evt[i]` in one cycle sets fault register bit i from the next clock edge onward. The transistor order from bit 7 down to bit 0 is HSB2, HSB1, LSB2, LSB1, HSA2, HSA1, LSA2, LSA1.
- R3: `uv_evt` sets fault bit 8 and `ov_evt` sets fault bit 9. A field value of 01 in bits 9..8 therefore means supply too low, and 10 means supply too high.
- R4: `twarn_evt` sets fault bit 10 (warning, information only) and `tsd_evt` sets fault bit 11 (thermal shutdown).
- R5: Once fault bit 11 is set, `bridge_off` is 1 and stays 1 until a fault register clear. A status/control write or clear does not release it.
- R6: A write to address 1 with data bit 12 set clears fault bits 11..0. A write to address 1 with data bit 12 clear has no effect, and data bits 11..0 are always ignored.
- R7: In the status/control register, `stall_evt` sets bit 8, a cycle with `iref_ok` low sets bit 7 (reference error), `oload_b_evt` sets bit 6 and `oload_a_evt` sets bit 5.
- R8: A write to address 0 with data bit 12 set clears status bits 8..5. It does not change the control bits or the fault register.
- R9: Every write to address 0 loads data bits 11, 10 and 9 into `pwm_mirror_en`, `filt_time_sel` (1 = 2.5 µs, 0 = 1.5 µs) and `pwm_freq_sel` (1 = 20 kHz, 0 = 30 kHz). These bits read back at the same positions. Status bits 4..0 read 0.
- R10: `pwm_mirror_lvl` equals the latched stall flag while `pwm_mirror_en` is 1, and is 0 otherwise.
- R11: When a clear and a set event for the same flag arrive in the same cycle, the clear wins and the flag reads 0. The flag sets again only if the event occurs in a later cycle.
- R12: Bit 12 of both registers always reads 0. Reads have no side effects. Write data cannot set a read-only flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | Write register select (0 status/control, 1 fault) |
| wr_data | input | 13 | Write data |
| rd_addr | input | 1 | Read register select (0 status/control, 1 fault) |
| rd_data | output | 13 | Read data of the selected register |
| ocp_evt | input | 8 | Per-transistor overcurrent events |
| uv_evt | input | 1 | Supply undervoltage event |
| ov_evt | input | 1 | Supply overvoltage event |
| twarn_evt | input | 1 | Temperature warning event |
| tsd_evt | input | 1 | Thermal shutdown event |
| stall_evt | input | 1 | Stall detected |
| oload_a_evt | input | 1 | Open load on bridge A |
| oload_b_evt | input | 1 | Open load on bridge B |
| iref_ok | input | 1 | High while the reference current is inside its window |
| bridge_off | output | 1 | Forces all bridges off |
| pwm_freq_sel | output | 1 | PWM frequency select |
| filt_time_sel | output | 1 | Glitch-filter time select |
| pwm_mirror_en | output | 1 | PWM pin follows the stall flag |
| pwm_mirror_lvl | output | 1 | Level driven on the PWM pin while mirroring |

## Verification
A flag whose stored state is wrong shows up on the read port at the first edge after its event or clear, because the read path has no register. A lost sticky bit appears as a 0 in any later read. A clear that is lost or reaches too far appears in the other register or on the control outputs at the next read. `bridge_off` and the mirror level are combinational functions of stored flags, so an error in the shutdown or stall state reaches these pins in the same cycle that the read port shows it.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int REG_W    = 13;
  localparam int CLR_BIT  = REG_W - 1;
  localparam int OCP_N    = 8;
  // fault register field positions
  localparam int F_UV     = OCP_N;
  localparam int F_OV     = OCP_N + 1;
  localparam int F_TW     = OCP_N + 2;
  localparam int F_TSD    = OCP_N + 3;
  localparam int FLT_N    = F_TSD + 1;
  // status/control register field positions
  localparam int S_OLA    = 5;
  localparam int S_OLB    = 6;
  localparam int S_REF    = 7;
  localparam int S_STALL  = 8;
  localparam int STAT_N   = S_STALL - S_OLA + 1;
  localparam int C_FREQ   = 9;
  localparam int C_FILT   = 10;
  localparam int C_MIRR   = 11;
  localparam int CTRL_N   = C_MIRR - C_FREQ + 1;

  typedef enum logic { SEL_STAT = 1'b0, SEL_FLT = 1'b1 } reg_sel_e;
endpackage

// File: rtl/fsb_rst_sync.sv
module fsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fsb_sticky.sv
module fsb_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (clr_i)        flag_d[i] = 1'b0;   // clear outranks a same-cycle event
      else if (set_i[i]) flag_d[i] = 1'b1;
      else              flag_d[i] = flag_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign q_o = flag_q;
endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ctrl_q;
  logic [W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (load_i) ctrl_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign q_o = ctrl_q;
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
  import fsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [OCP_N-1:0]  ocp_evt,
  input  logic              uv_evt,
  input  logic              ov_evt,
  input  logic              twarn_evt,
  input  logic              tsd_evt,
  input  logic              stall_evt,
  input  logic              oload_a_evt,
  input  logic              oload_b_evt,
  input  logic              iref_ok,
  output logic              bridge_off,
  output logic              pwm_freq_sel,
  output logic              filt_time_sel,
  output logic              pwm_mirror_en,
  output logic              pwm_mirror_lvl
);
  logic              rst_sync_n;
  logic              wr_stat;
  logic              wr_flt;
  logic              clr_stat;
  logic              clr_flt;
  logic [FLT_N-1:0]  flt_set;
  logic [FLT_N-1:0]  flt_q;
  logic [STAT_N-1:0] st_set;
  logic [STAT_N-1:0] st_q;
  logic [CTRL_N-1:0] ctrl_q;
  logic [REG_W-1:0]  stat_word;
  logic [REG_W-1:0]  flt_word;

  fsb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // write decode
  always_comb begin
    wr_stat  = wr_en && (reg_sel_e'(wr_addr) == SEL_STAT);
    wr_flt   = wr_en && (reg_sel_e'(wr_addr) == SEL_FLT);
    clr_stat = wr_stat && wr_data[CLR_BIT];
    clr_flt  = wr_flt  && wr_data[CLR_BIT];
  end

  // event collection, ordered by field position
  always_comb begin
    flt_set = {tsd_evt, twarn_evt, ov_evt, uv_evt, ocp_evt};
    st_set  = {stall_evt, ~iref_ok, oload_b_evt, oload_a_evt};
  end

  fsb_sticky #(.W(FLT_N)) u_flt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(flt_set),
    .clr_i(clr_flt),
    .q_o  (flt_q)
  );

  fsb_sticky #(.W(STAT_N)) u_stat (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(st_set),
    .clr_i(clr_stat),
    .q_o  (st_q)
  );

  fsb_ctrl #(.W(CTRL_N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load_i(wr_stat),
    .d_i   (wr_data[C_MIRR:C_FREQ]),
    .q_o   (ctrl_q)
  );

  // read words; clear bits always read 0
  always_comb begin
    flt_word                  = '0;
    flt_word[FLT_N-1:0]       = flt_q;
    stat_word                 = '0;
    stat_word[S_STALL:S_OLA]  = st_q;
    stat_word[C_MIRR:C_FREQ]  = ctrl_q;
    rd_data = (reg_sel_e'(rd_addr) == SEL_FLT) ? flt_word : stat_word;
  end

  always_comb begin
    bridge_off     = flt_q[F_TSD];
    pwm_freq_sel   = ctrl_q[C_FREQ - C_FREQ];
    filt_time_sel  = ctrl_q[C_FILT - C_FREQ];
    pwm_mirror_en  = ctrl_q[C_MIRR - C_FREQ];
    pwm_mirror_lvl = pwm_mirror_en && st_q[S_STALL - S_OLA];
  end
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker
  import fsb_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic [OCP_N-1:0]  ocp_evt,
  input logic              tsd_evt,
  input logic [FLT_N-1:0]  flt_q,
  input logic [STAT_N-1:0] st_q,
  input logic [CTRL_N-1:0] ctrl_q,
  input logic [REG_W-1:0]  rd_data,
  input logic              bridge_off
);
  logic fclr;
  logic sclr;
  assign fclr = wr_en && wr_addr && wr_data[CLR_BIT];
  assign sclr = wr_en && !wr_addr && wr_data[CLR_BIT];

  assert_ocp_set_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fclr |=> ((flt_q[OCP_N-1:0] & $past(ocp_evt)) == $past(ocp_evt)));

  assert_tsd_off_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tsd_evt && !fclr) |=> bridge_off);

  assert_off_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bridge_off && !fclr) |=> bridge_off);

  assert_flt_clear_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fclr |=> (flt_q == '0));

  assert_flt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fclr |=> ((flt_q & $past(flt_q)) == $past(flt_q)));

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sclr |=> (st_q == '0 && $stable(flt_q) == (flt_q == $past(flt_q))));

  assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_addr) |=> (ctrl_q == $past(wr_data[C_MIRR:C_FREQ])));

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && !wr_addr) |=> $stable(ctrl_q));

  assert_clr_bit_zero_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[CLR_BIT] == 1'b0);
endmodule

bind fault_status_bank fsb_checker u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ocp_evt   (ocp_evt),
  .tsd_evt   (tsd_evt),
  .flt_q     (flt_q),
  .st_q      (st_q),
  .ctrl_q    (ctrl_q),
  .rd_data   (rd_data),
  .bridge_off(bridge_off)
);

// File: tb/tb_fault_status_bank.sv
module tb_fault_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [12:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [12:0] rd_data;
  logic [7:0]  ocp_evt = '0;
  logic        uv_evt = 1'b0, ov_evt = 1'b0, twarn_evt = 1'b0, tsd_evt = 1'b0;
  logic        stall_evt = 1'b0, oload_a_evt = 1'b0, oload_b_evt = 1'b0;
  logic        iref_ok = 1'b1;
  logic        bridge_off, pwm_freq_sel, filt_time_sel, pwm_mirror_en, pwm_mirror_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [11:0] m_flt = '0;   // fault bits 11..0
  logic [3:0]  m_st  = '0;   // {stall, referr, olb, ola}
  logic [2:0]  m_ctl = '0;   // {mirror, filt, freq}

  always #4 clk = ~clk;      // 125 MHz

  fault_status_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ocp_evt(ocp_evt), .uv_evt(uv_evt),
    .ov_evt(ov_evt), .twarn_evt(twarn_evt), .tsd_evt(tsd_evt), .stall_evt(stall_evt),
    .oload_a_evt(oload_a_evt), .oload_b_evt(oload_b_evt), .iref_ok(iref_ok),
    .bridge_off(bridge_off), .pwm_freq_sel(pwm_freq_sel), .filt_time_sel(filt_time_sel),
    .pwm_mirror_en(pwm_mirror_en), .pwm_mirror_lvl(pwm_mirror_lvl)
  );

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic compare_all(input string req);
    rd_addr = 1'b1; #1;
    check(req, rd_data, {1'b0, m_flt});
    rd_addr = 1'b0; #1;
    check(req, rd_data, {1'b0, m_ctl, m_st, 5'b0});
    check("R5", {12'b0, bridge_off}, {12'b0, m_flt[11]});
    check("R9", {10'b0, pwm_mirror_en, filt_time_sel, pwm_freq_sel}, {10'b0, m_ctl});
    check("R10", {12'b0, pwm_mirror_lvl}, {12'b0, m_ctl[2] & m_st[3]});
  endtask

  // called at a negedge with inputs already driven; one clock edge later compares
  task automatic tick(input string req);
    logic fclr, sclr;
    fclr = wr_en && wr_addr && wr_data[12];
    sclr = wr_en && !wr_addr && wr_data[12];
    if (fclr) m_flt = '0;
    else      m_flt = m_flt | {tsd_evt, twarn_evt, ov_evt, uv_evt, ocp_evt};
    if (sclr) m_st = '0;
    else      m_st = m_st | {stall_evt, ~iref_ok, oload_b_evt, oload_a_evt};
    if (wr_en && !wr_addr) m_ctl = wr_data[11:9];
    @(negedge clk);
    wr_en = 0; wr_data = '0; ocp_evt = '0; uv_evt = 0; ov_evt = 0; twarn_evt = 0;
    tsd_evt = 0; stall_evt = 0; oload_a_evt = 0; oload_b_evt = 0; iref_ok = 1;
    compare_all(req);
  endtask

  task automatic wr(input logic a, input logic [12:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state, with events applied during reset
    repeat (3) @(negedge clk);
    ocp_evt = 8'hFF; tsd_evt = 1; stall_evt = 1;
    @(negedge clk);
    ocp_evt = '0; tsd_evt = 0; stall_evt = 0;
    compare_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1");

    // R2: sweep every overcurrent pattern, clearing now and then (R6 data ignored)
    for (int i = 0; i < 256; i++) begin
      ocp_evt = i[7:0];
      if (i % 16 == 15) wr(1'b1, 13'h1FFF);
      tick("R2");
      if (i % 16 == 7) begin wr(1'b1, 13'h1000); tick("R6"); end
    end
    wr(1'b1, 13'h1000); tick("R6");

    // R3: supply field
    uv_evt = 1; tick("R3");
    wr(1'b1, 13'h1000); tick("R6");
    ov_evt = 1; tick("R3");
    uv_evt = 1; tick("R3");
    wr(1'b1, 13'h1000); tick("R6");

    // R4/R5: temperature and shutdown hold
    twarn_evt = 1; tick("R4");
    tsd_evt = 1; tick("R4");
    repeat (3) tick("R5");
    wr(1'b0, 13'h1000); tick("R5");         // status clear does not release
    wr(1'b1, 13'h0FFF); tick("R6");         // no clear bit: nothing happens
    tick("R5");
    wr(1'b1, 13'h1000); tick("R5");         // releases
    tick("R5");

    // R7: all combinations of status events, with periodic clears
    for (int i = 0; i < 16; i++) begin
      {stall_evt, iref_ok, oload_b_evt, oload_a_evt} = {i[3], ~i[2], i[1], i[0]};
      tick("R7");
      if (i % 4 == 3) begin wr(1'b0, 13'h1000); tick("R8"); end
    end

    // R9: every control value with all other data bits set
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, {1'b0, i[2:0], 9'h1FF}); tick("R9");
      tick("R9");
    end

    // R8: status clear leaves control and fault alone
    wr(1'b0, 13'b0_111_000000000); tick("R9");
    ocp_evt = 8'hA5; tsd_evt = 1; stall_evt = 1; oload_a_evt = 1; iref_ok = 0; tick("R7");
    wr(1'b0, 13'b1_111_000000000); tick("R8");

    // R10: mirror level follows stall only while enabled
    stall_evt = 1; tick("R10");
    wr(1'b0, 13'b0_011_000000000); tick("R10");
    wr(1'b0, 13'b0_100_000000000); tick("R10");
    wr(1'b0, 13'b1_100_000000000); tick("R10");

    // R11: clear beats a same-cycle event, event later re-sets
    ocp_evt = 8'h3C; tsd_evt = 1; wr(1'b1, 13'h1000); tick("R11");
    ocp_evt = 8'h3C; tick("R11");
    stall_evt = 1; oload_b_evt = 1; wr(1'b0, 13'h1000); tick("R11");
    stall_evt = 1; tick("R11");

    // R12: reads have no side effects; writes cannot set read-only flags
    wr(1'b1, 13'h1000); tick("R12");
    wr(1'b1, 13'h0FFF); tick("R12");
    wr(1'b0, 13'h01E0); tick("R12");
    for (int i = 0; i < 8; i++) begin
      rd_addr = i[0]; #1;
      compare_all("R12");
      @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule